// File: doc/BRIEF.md
# Vector Element-Group Legality Checker

This block sits in the decode stage of a vector unit and decides, for one instruction that treats several consecutive elements as a single wide element, whether that instruction may issue. It takes the active element-width and register-multiplier settings, the element count `vl` and the start index `vstart`. From the opcode it takes the group size and a class code that lists the element widths the opcode accepts. It also takes the three register indices of the instruction. It raises one illegal flag when any rule is broken.

When the instruction is legal, the block also reports the width of one group in bits and the number of groups that `vl` covers. It reports how many vector registers one group spans and how many groups fit in one register. It also flags whether any work remains, which is the case when `vstart` is below `vl`. The widths it reports are powers of two, so every quotient is computed with shifts of base-2 logarithms. The results are combinational, or held in a register stage when `REG_OUT` is set, which is the default.

Top module: `vegrp_legal_chk`

## Requirements
- R1: When legal, `egw` equals the element width (8 shifted left by `sew_code`) times the group size, so it is either 128 or 256.
- R2: The group size comes only from `egs_sel`: 0 selects 4 elements and 1 selects 8 elements. None of the vtype-derived inputs changes it.
- R3: `sew_code` values 4 to 7 (widths above 64 bits) are reserved and raise `illegal`. Codes 0 to 3 mean 8, 16, 32 and 64 bits.
- R4: `op_cls` lists the widths the opcode accepts. Code 0 accepts 32 bits only, 1 accepts 32 or 64, and 2 accepts 64 only. Code 3 accepts none. Any other width raises `illegal`.
- R5: Only three combinations are legal: 4 groups of 32-bit elements, 8 of 32-bit, and 4 of 64-bit. Eight 64-bit elements raise `illegal`.
- R6: `vl` counts elements. If it is not a multiple of the group size, `illegal` is raised.
- R7: `vstart` counts elements. If it is not a multiple of the group size, `illegal` is raised.
- R8: When legal, `grp_cnt` equals `vl` divided by the group size, and `grp_active` is 1 exactly when `vstart < vl`.
- R9: When legal, `regs_per_grp` is `egw/VLEN` if `egw > VLEN` and 1 otherwise. `grp_per_reg` is `VLEN/egw` if `egw <= VLEN` and 0 otherwise.
- R10: `lmul_code` 0 to 3 means 1, 2, 4 and 8 registers, and 5 to 7 (fractional) mean 1 register. Code 4 is reserved and raises `illegal`. The span is the larger of the multiplier register count and `regs_per_grp`. Each of `vd_idx`, `vs1_idx` and `vs2_idx` must be a multiple of the span, or `illegal` is raised.
- R11: While `illegal` is 1, `egw`, `grp_cnt`, `regs_per_grp`, `grp_per_reg` and `grp_active` are all 0.
- R12: With `REG_OUT`=1, outputs change on the clock edge after the inputs. Asserting `rst_n` low at once forces `illegal`=1 and all other outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sew_code | input | 3 | Element-width code from vtype |
| lmul_code | input | 3 | Register-multiplier code from vtype |
| vl | input | VL_W | Vector length in elements |
| vstart | input | VL_W | Start element index |
| egs_sel | input | 1 | Group size from the opcode (0: 4, 1: 8) |
| op_cls | input | 2 | Opcode width class |
| vd_idx | input | 5 | Destination register index |
| vs1_idx | input | 5 | First source register index |
| vs2_idx | input | 5 | Second source register index |
| illegal | output | 1 | Instruction must not issue |
| egw | output | 10 | Group width in bits |
| grp_cnt | output | VL_W | Groups covered by vl |
| regs_per_grp | output | 4 | Registers one group spans |
| grp_per_reg | output | VL_W | Groups held by one register |
| grp_active | output | 1 | Work remains (vstart below vl) |

## Verification
All six outputs come from one register stage in the default build. Every result for a set of inputs therefore appears on the rising edge that follows the falling edge on which those inputs were driven. The bench drives each input set on a falling edge, waits for the next rising edge, and compares every output at the following falling edge, one clock after the stimulus. One dedicated check samples just before that rising edge, to confirm that the previous result is still held. The reset check samples a nanosecond after `rst_n` falls, with no clock edge in between, because that path is asynchronous.

// File: rtl/vegrp_pkg.sv
package vegrp_pkg;

  localparam int EGW_W     = 10;
  localparam int SPAN_W    = 4;
  localparam int REG_IDX_W = 5;
  localparam int NUM_OPS   = 3;

  localparam logic [2:0] SEWC_32   = 3'd2;
  localparam logic [2:0] SEWC_64   = 3'd3;
  localparam logic [2:0] LMUL_RSVD = 3'd4;

  typedef enum logic [1:0] {
    CLS_W32    = 2'd0,
    CLS_W32_64 = 2'd1,
    CLS_W64    = 2'd2,
    CLS_NONE   = 2'd3
  } op_cls_e;

  typedef enum logic {
    GRP4 = 1'b0,
    GRP8 = 1'b1
  } egs_e;

  function automatic logic class_allows(input op_cls_e cls, input logic [2:0] sew);
    logic ok;
    case (cls)
      CLS_W32:    ok = (sew == SEWC_32);
      CLS_W32_64: ok = (sew == SEWC_32) || (sew == SEWC_64);
      CLS_W64:    ok = (sew == SEWC_64);
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/vegrp_cfg_decode.sv
module vegrp_cfg_decode
  import vegrp_pkg::*;
(
  input  logic [2:0]        sew_code,
  input  logic [2:0]        lmul_code,
  input  egs_e              egs_sel,
  input  op_cls_e           op_cls,
  output logic              cfg_bad,
  output logic [3:0]        egw_log,
  output logic [SPAN_W-1:0] lmul_regs
);

  logic width_ok;
  logic combo_ok;
  logic lmul_ok;
  logic [3:0] eew_log;
  logic [3:0] egs_log;

  always_comb begin
    width_ok  = class_allows(op_cls, sew_code);
    // eight 64-bit elements is not a supported pairing
    combo_ok  = !((egs_sel == GRP8) && (sew_code == SEWC_64));
    lmul_ok   = (lmul_code != LMUL_RSVD);
    cfg_bad   = sew_code[2] | !width_ok | !combo_ok | !lmul_ok;
    eew_log   = 4'(sew_code) + 4'd3;
    egs_log   = (egs_sel == GRP8) ? 4'd3 : 4'd2;
    egw_log   = eew_log + egs_log;
    // fractional settings still occupy one whole register
    lmul_regs = lmul_code[2] ? SPAN_W'(1) : (SPAN_W'(1) << lmul_code[1:0]);
  end

endmodule

// File: rtl/vegrp_len_check.sv
module vegrp_len_check
  import vegrp_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic [VL_W-1:0] vl,
  input  logic [VL_W-1:0] vstart,
  input  egs_e            egs_sel,
  output logic            len_bad,
  output logic [VL_W-1:0] grp_cnt,
  output logic            grp_active
);

  logic [2:0] rem_mask;

  always_comb begin
    rem_mask   = (egs_sel == GRP8) ? 3'b111 : 3'b011;
    len_bad    = (|(vl[2:0] & rem_mask)) | (|(vstart[2:0] & rem_mask));
    grp_cnt    = (egs_sel == GRP8) ? (vl >> 3) : (vl >> 2);
    grp_active = (vstart < vl);
  end

endmodule

// File: rtl/vegrp_geom.sv
module vegrp_geom
  import vegrp_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int GPR_W = 8
) (
  input  logic [3:0]        egw_log,
  input  logic [SPAN_W-1:0] lmul_regs,
  output logic [EGW_W-1:0]  egw,
  output logic [SPAN_W-1:0] regs_per_grp,
  output logic [GPR_W-1:0]  grp_per_reg,
  output logic [SPAN_W-1:0] span
);

  localparam int VLEN_LOG = $clog2(VLEN);
  localparam logic [3:0] VLEN_LOG4 = 4'(VLEN_LOG);

  always_comb begin
    egw = EGW_W'(1) << egw_log;
    if (egw_log > VLEN_LOG4) begin
      regs_per_grp = SPAN_W'(1) << (egw_log - VLEN_LOG4);
      grp_per_reg  = '0;
    end else begin
      regs_per_grp = SPAN_W'(1);
      grp_per_reg  = GPR_W'(1) << (VLEN_LOG4 - egw_log);
    end
    span = (lmul_regs > regs_per_grp) ? lmul_regs : regs_per_grp;
  end

endmodule

// File: rtl/vegrp_align_check.sv
module vegrp_align_check
  import vegrp_pkg::*;
#(
  parameter int N_OPS = 3
) (
  input  logic [SPAN_W-1:0]                span,
  input  logic [N_OPS-1:0][REG_IDX_W-1:0]  idx,
  output logic                             align_bad
);

  logic [REG_IDX_W-1:0] low_mask;
  logic [N_OPS-1:0]     op_bad;

  assign low_mask = {{(REG_IDX_W-SPAN_W){1'b0}}, span} - REG_IDX_W'(1);

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    assign op_bad[g] = |(idx[g] & low_mask);
  end

  assign align_bad = |op_bad;

endmodule

// File: rtl/vegrp_legal_chk.sv
module vegrp_legal_chk
  import vegrp_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter bit REG_OUT = 1'b1,
  localparam int VL_W   = $clog2(VLEN) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           sew_code,
  input  logic [2:0]           lmul_code,
  input  logic [VL_W-1:0]      vl,
  input  logic [VL_W-1:0]      vstart,
  input  logic                 egs_sel,
  input  logic [1:0]           op_cls,
  input  logic [REG_IDX_W-1:0] vd_idx,
  input  logic [REG_IDX_W-1:0] vs1_idx,
  input  logic [REG_IDX_W-1:0] vs2_idx,
  output logic                 illegal,
  output logic [EGW_W-1:0]     egw,
  output logic [VL_W-1:0]      grp_cnt,
  output logic [SPAN_W-1:0]    regs_per_grp,
  output logic [VL_W-1:0]      grp_per_reg,
  output logic                 grp_active
);

  logic                  cfg_bad, len_bad, align_bad;
  logic [3:0]            egw_log;
  logic [SPAN_W-1:0]     lmul_regs, span, rpg_c;
  logic [EGW_W-1:0]      egw_c;
  logic [VL_W-1:0]       gcnt_c, gpr_c;
  logic                  act_c;
  logic [NUM_OPS-1:0][REG_IDX_W-1:0] op_idx;

  logic                  ill_d;
  logic [EGW_W-1:0]      egw_d;
  logic [VL_W-1:0]       gcnt_d, gpr_d;
  logic [SPAN_W-1:0]     rpg_d;
  logic                  act_d;

  assign op_idx = {vs2_idx, vs1_idx, vd_idx};

  vegrp_cfg_decode u_cfg (
    .sew_code  (sew_code),
    .lmul_code (lmul_code),
    .egs_sel   (egs_e'(egs_sel)),
    .op_cls    (op_cls_e'(op_cls)),
    .cfg_bad   (cfg_bad),
    .egw_log   (egw_log),
    .lmul_regs (lmul_regs)
  );

  vegrp_len_check #(.VL_W(VL_W)) u_len (
    .vl         (vl),
    .vstart     (vstart),
    .egs_sel    (egs_e'(egs_sel)),
    .len_bad    (len_bad),
    .grp_cnt    (gcnt_c),
    .grp_active (act_c)
  );

  vegrp_geom #(.VLEN(VLEN), .GPR_W(VL_W)) u_geom (
    .egw_log      (egw_log),
    .lmul_regs    (lmul_regs),
    .egw          (egw_c),
    .regs_per_grp (rpg_c),
    .grp_per_reg  (gpr_c),
    .span         (span)
  );

  vegrp_align_check #(.N_OPS(NUM_OPS)) u_align (
    .span      (span),
    .idx       (op_idx),
    .align_bad (align_bad)
  );

  // next-state: a rejected instruction reports no geometry
  always_comb begin
    ill_d  = cfg_bad | len_bad | align_bad;
    egw_d  = ill_d ? '0 : egw_c;
    gcnt_d = ill_d ? '0 : gcnt_c;
    rpg_d  = ill_d ? '0 : rpg_c;
    gpr_d  = ill_d ? '0 : gpr_c;
    act_d  = ill_d ? 1'b0 : act_c;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        illegal      <= 1'b1;
        egw          <= '0;
        grp_cnt      <= '0;
        regs_per_grp <= '0;
        grp_per_reg  <= '0;
        grp_active   <= 1'b0;
      end else begin
        illegal      <= ill_d;
        egw          <= egw_d;
        grp_cnt      <= gcnt_d;
        regs_per_grp <= rpg_d;
        grp_per_reg  <= gpr_d;
        grp_active   <= act_d;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk   = clk & rst_n;
    assign illegal      = ill_d;
    assign egw          = egw_d;
    assign grp_cnt      = gcnt_d;
    assign regs_per_grp = rpg_d;
    assign grp_per_reg  = gpr_d;
    assign grp_active   = act_d;
  end

endmodule

// File: rtl/vegrp_legal_chk_sva.sv
module vegrp_legal_chk_sva
  import vegrp_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter bit REG_OUT = 1'b1,
  localparam int VL_W   = $clog2(VLEN) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        sew_code,
  input logic [VL_W-1:0]   vl,
  input logic              illegal,
  input logic [EGW_W-1:0]  egw,
  input logic [VL_W-1:0]   grp_cnt,
  input logic [SPAN_W-1:0] regs_per_grp,
  input logic [VL_W-1:0]   grp_per_reg,
  input logic              grp_active
);

  logic [VL_W-1:0] vl_ref;
  logic [2:0]      sew_ref;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vl_ref  <= '0;
        sew_ref <= 3'd0;
      end else begin
        vl_ref  <= vl;
        sew_ref <= sew_code;
      end
    end
  end else begin : g_now
    assign vl_ref  = vl;
    assign sew_ref = sew_code;
  end

  assert_zero_when_bad_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (egw == '0 && grp_cnt == '0 && regs_per_grp == '0 &&
                 grp_per_reg == '0 && !grp_active));

  assert_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> (egw == EGW_W'(128) || egw == EGW_W'(256)));

  assert_span_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> $onehot(regs_per_grp));

  assert_fit_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> (regs_per_grp == SPAN_W'(1) || grp_per_reg == '0));

  assert_vl_multiple_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> (vl_ref[1:0] == 2'b00));

  assert_sew_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> (sew_ref[2] == 1'b0));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> ((grp_cnt << 2) <= vl_ref));

endmodule

bind vegrp_legal_chk vegrp_legal_chk_sva #(.VLEN(VLEN), .REG_OUT(REG_OUT)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .sew_code     (sew_code),
  .vl           (vl),
  .illegal      (illegal),
  .egw          (egw),
  .grp_cnt      (grp_cnt),
  .regs_per_grp (regs_per_grp),
  .grp_per_reg  (grp_per_reg),
  .grp_active   (grp_active)
);

// File: tb/sim_vegrp_legal_chk.sv
`timescale 1ns/1ps
module sim_vegrp_legal_chk;

  localparam int VLEN = 128;
  localparam int VL_W = $clog2(VLEN) + 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2:0]      sew_code, lmul_code;
  logic [VL_W-1:0] vl, vstart;
  logic            egs_sel;
  logic [1:0]      op_cls;
  logic [4:0]      vd_idx, vs1_idx, vs2_idx;
  logic            illegal;
  logic [9:0]      egw;
  logic [VL_W-1:0] grp_cnt;
  logic [3:0]      regs_per_grp;
  logic [VL_W-1:0] grp_per_reg;
  logic            grp_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vegrp_legal_chk #(.VLEN(VLEN), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sew_code(sew_code), .lmul_code(lmul_code),
    .vl(vl), .vstart(vstart), .egs_sel(egs_sel), .op_cls(op_cls),
    .vd_idx(vd_idx), .vs1_idx(vs1_idx), .vs2_idx(vs2_idx),
    .illegal(illegal), .egw(egw), .grp_cnt(grp_cnt),
    .regs_per_grp(regs_per_grp), .grp_per_reg(grp_per_reg),
    .grp_active(grp_active)
  );

  // arithmetic reference, written from the requirements
  task automatic model(output bit ill, output int e_egw, output int e_cnt,
                       output int e_rpg, output int e_gpr, output bit e_act,
                       output string why);
    int eew, g, w, r, lm, sp;
    why = "";
    eew = 8 << sew_code;
    g   = egs_sel ? 8 : 4;
    w   = eew * g;
    r   = (w > VLEN) ? w / VLEN : 1;
    lm  = (lmul_code < 4) ? (1 << lmul_code) : 1;
    sp  = (lm > r) ? lm : r;
    if (sew_code >= 4) why = "R3";
    else if (!((op_cls == 0 && eew == 32) ||
               (op_cls == 1 && (eew == 32 || eew == 64)) ||
               (op_cls == 2 && eew == 64))) why = "R4";
    else if (g == 8 && eew == 64) why = "R5";
    else if (lmul_code == 4) why = "R10";
    else if (int'(vl) % g != 0) why = "R6";
    else if (int'(vstart) % g != 0) why = "R7";
    else if ((vd_idx % sp) != 0 || (vs1_idx % sp) != 0 || (vs2_idx % sp) != 0) why = "R10";
    ill = (why != "");
    if (ill) begin
      e_egw = 0; e_cnt = 0; e_rpg = 0; e_gpr = 0; e_act = 1'b0;
    end else begin
      e_egw = w;
      e_cnt = int'(vl) / g;
      e_rpg = r;
      e_gpr = (w <= VLEN) ? VLEN / w : 0;
      e_act = (vstart < vl);
    end
  endtask

  task automatic compare(input string ctx);
    bit ill, act; int ew, ec, er, eg; string why, tag;
    model(ill, ew, ec, er, eg, act, why);
    n_chk++;
    tag = ill ? why : "R2";
    if (illegal !== ill) begin
      n_bad++;
      $display("FAIL %s %s illegal act=%0b exp=%0b (sew=%0d lmul=%0d egs=%0b cls=%0d vl=%0d vst=%0d regs=%0d/%0d/%0d)",
               tag, ctx, illegal, ill, sew_code, lmul_code, egs_sel, op_cls, vl, vstart, vd_idx, vs1_idx, vs2_idx);
    end else if (ill && (egw != 0 || grp_cnt != 0 || regs_per_grp != 0 || grp_per_reg != 0 || grp_active)) begin
      n_bad++;
      $display("FAIL R11 %s outputs act=%0d/%0d/%0d/%0d/%0b exp=0/0/0/0/0",
               ctx, egw, grp_cnt, regs_per_grp, grp_per_reg, grp_active);
    end else if (!ill && int'(egw) != ew) begin
      n_bad++;
      $display("FAIL R1 %s egw act=%0d exp=%0d", ctx, egw, ew);
    end else if (!ill && (int'(grp_cnt) != ec || grp_active !== act)) begin
      n_bad++;
      $display("FAIL R8 %s cnt/active act=%0d/%0b exp=%0d/%0b", ctx, grp_cnt, grp_active, ec, act);
    end else if (!ill && (int'(regs_per_grp) != er || int'(grp_per_reg) != eg)) begin
      n_bad++;
      $display("FAIL R9 %s rpg/gpr act=%0d/%0d exp=%0d/%0d", ctx, regs_per_grp, grp_per_reg, er, eg);
    end
  endtask

  task automatic drive(input int s, input int l, input int e, input int c,
                       input int vlen_in, input int vst, input int d, input int a, input int b);
    sew_code = 3'(s); lmul_code = 3'(l); egs_sel = 1'(e); op_cls = 2'(c);
    vl = VL_W'(vlen_in); vstart = VL_W'(vst);
    vd_idx = 5'(d); vs1_idx = 5'(a); vs2_idx = 5'(b);
  endtask

  // inputs on a falling edge, result registered at the rising edge, sampled next falling edge
  task automatic apply(input string ctx, input int s, input int l, input int e, input int c,
                       input int vlen_in, input int vst, input int d, input int a, input int b);
    drive(s, l, e, c, vlen_in, vst, d, a, b);
    @(posedge clk);
    @(negedge clk);
    compare(ctx);
  endtask

  initial begin
    int vls[6];
    int vss[4];
    vls = '{0, 4, 8, 24, 6, 128};
    vss = '{0, 4, 16, 2};
    rst_n = 1'b0;
    drive(2, 0, 0, 0, 4, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R12 reset state
    n_chk++;
    if (illegal !== 1'b1 || egw != 0 || grp_cnt != 0 || regs_per_grp != 0 || grp_per_reg != 0 || grp_active) begin
      n_bad++;
      $display("FAIL R12 reset act=%0b/%0d exp=1/0", illegal, egw);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5 R8 directed: 4x32 with vl=12, vstart=4
    apply("dir4x32", 2, 0, 0, 1, 12, 4, 2, 5, 31);
    // R5 8x64 always rejected
    apply("dir8x64", 3, 0, 1, 1, 16, 0, 0, 0, 0);
    // R9 wide group: 4x64 spans two registers, odd index rejected (R10)
    apply("dirwide", 3, 0, 0, 2, 8, 0, 2, 4, 6);
    apply("dirodd", 3, 0, 0, 2, 8, 0, 2, 4, 7);

    // R12 latency: new legal input must not show before the edge
    drive(2, 0, 0, 0, 8, 0, 0, 0, 0);
    #1;
    n_chk++;
    if (illegal !== 1'b1) begin
      n_bad++;
      $display("FAIL R12 early change illegal act=%0b exp=1", illegal);
    end
    @(posedge clk);
    @(negedge clk);
    compare("latency R12");

    // R2 R3 R4 R5 R6 R7 R8 R10 sweep over every vtype/opcode code
    for (int s = 0; s < 8; s++)
      for (int l = 0; l < 8; l++)
        for (int e = 0; e < 2; e++)
          for (int c = 0; c < 4; c++)
            for (int i = 0; i < 6; i++)
              for (int j = 0; j < 4; j++)
                apply("cfg sweep", s, l, e, c, vls[i], vss[j], 0, 8, 16);

    // R9 R10 alignment sweep: each operand index against each span
    for (int s = 2; s < 4; s++)
      for (int e = 0; e < 2; e++)
        for (int l = 0; l < 8; l++)
          for (int op = 0; op < 3; op++)
            for (int r = 0; r < 32; r++)
              if (l != 4)
                apply("align sweep", s, l, e, 1, 24, 8,
                      (op == 0) ? r : 0, (op == 1) ? r : 0, (op == 2) ? r : 0);

    // R12 asynchronous reset mid-run
    apply("pre-reset", 2, 0, 0, 0, 8, 0, 0, 0, 0);
    rst_n = 1'b0;
    #1;
    n_chk++;
    if (illegal !== 1'b1 || egw != 0 || grp_active) begin
      n_bad++;
      $display("FAIL R12 async reset act=%0b/%0d exp=1/0", illegal, egw);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule